// File: doc/BRIEF.md
# Sprite Attribute Fetch and Host Slot Sequencer

This block drives the fast video memory during the rendering half of each scanline. It repeats a fixed 16-clock sequence of five phases. In the first phase it reads a sprite number from the sprite list. In the next three phases it reads that sprite's zoom word, its vertical word (Y position, size and sticky flag) and its X word. The fifth phase is a memory slot for the host CPU. A pulse on `line_start` restarts the sequence at list entry 0. After that pulse the block fetches `SEQS_PER_LINE` sprites, and it then stops fetching until the next pulse. The sequence keeps running between lines, so the host slot is always available.

The host sees an address register, a step (modulo) register, a write latch and a read latch. In every host slot that has no write waiting, the block reads the word at the address register into the read latch. A write to the write latch marks a write as pending. The next host slot stores the latch at the address register and then adds the step value to the address register. A second write that arrives while one is still pending waits in a one-deep queue. The host must leave at least 24 clocks between data writes.

The fetched attributes leave the block as a one-cycle valid pulse with the data beside it. The renderer consumes data at the fixed memory cadence. For that reason the output has no ready input and the block never stalls: each pulse must be taken in the cycle it is shown.

Top module: `sprite_fetch_seq`

## Requirements
- R1: Within one sequence the memory address is the list entry, then ZOOM_BASE (0x000) + n, then YPOS_BASE (0x200) + n, then XPOS_BASE (0x400) + n, then the host address register. Here n is the sprite number read in that sequence.
- R2: A sequence lasts 16 clocks. The list phase lasts 4 clocks and each of the other four phases lasts 3 clocks. Counted from the clock edge that samples `line_start`, the list phase covers relative cycles 0..3, zoom 4..6, vertical 7..9, X 10..12 and host 13..15.
- R3: `spr_valid` is a single-cycle pulse. For sequence k of a line it rises 16*(k+1) clocks after the edge that samples `line_start`. It carries `spr_index` = k and the zoom, vertical and X words fetched in that sequence.
- R4: The list is read at 0x600 + k when `builder_bank` = 1 and at 0x680 + k when `builder_bank` = 0, so the block reads the bank the builder is not writing. `builder_bank` is sampled at the `line_start` edge.
- R5: Exactly 96 pulses follow each `line_start`. No pulse appears outside a line.
- R6: In a host slot with no pending write, the word at the host address register is loaded into `host_rdata`.
- R7: After a pulse on `host_data_we`, `host_wr_pending` is 1. The next host slot writes the latch to the host address, and the address register then advances by the step value.
- R8: A data write made while another is pending is kept. It is written in a later host slot, at the address already advanced by the first write.
- R9: After reset `spr_valid`, `mem_we`, `host_wr_pending` and `host_rdata` are all 0.
- R10: The sprite number is bits [8:0] of the list word. The upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Pulse that restarts the sequence for a new line |
| builder_bank | input | 1 | List bank the builder is currently writing |
| mem_addr | output | 16 | Video memory word address |
| mem_we | output | 1 | Memory write enable (only asserted in the host slot) |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one clock after the address |
| host_addr_we | input | 1 | Load the host address register from host_wdata |
| host_mod_we | input | 1 | Load the step register from host_wdata |
| host_data_we | input | 1 | Load the write latch and request a write |
| host_wdata | input | 16 | Host write value |
| host_rdata | output | 16 | Read latch |
| host_wr_pending | output | 1 | A write is waiting for a host slot |
| spr_valid | output | 1 | Attribute set valid (one cycle) |
| spr_index | output | 7 | Position of the sprite within the line |
| spr_num | output | 9 | Sprite number |
| spr_zoom | output | 16 | Zoom word |
| spr_ypos | output | 16 | Vertical word |
| spr_xpos | output | 16 | X word |

## Verification
The fetch path runs over two full lines, one per value of `builder_bank`. The two list banks hold different sprite numbers with different upper garbage bits. This shows whether the wrong bank was read and whether the number masking is wrong. The address in every cycle of the first sequence is compared with the expected phase layout, and every pulse is timed against 16*(k+1) clocks, so a phase of the wrong length shows up. Host traffic covers three cases: a plain background read, a single write with a non-unit step, and a pair of back-to-back writes. These tell apart a lost queued write, a wrong address step, and a read latch that is not refreshed after writes.

// File: rtl/sprfetch_pkg.sv
package sprfetch_pkg;
  typedef enum logic [2:0] {
    PH_LIST = 3'd0,
    PH_ZOOM = 3'd1,
    PH_YPOS = 3'd2,
    PH_XPOS = 3'd3,
    PH_HOST = 3'd4
  } phase_e;
endpackage

// File: rtl/seq_phase_timer.sv
module seq_phase_timer
  import sprfetch_pkg::*;
#(
  parameter int LIST_CLKS = 4,
  parameter int STEP_CLKS = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  output phase_e phase,
  output logic   phase_end
);
  localparam int MAXC  = (LIST_CLKS > STEP_CLKS) ? LIST_CLKS : STEP_CLKS;
  localparam int CNT_W = $clog2(MAXC + 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    if (phase_q == PH_LIST) last_cnt = CNT_W'(LIST_CLKS - 1);
    else                    last_cnt = CNT_W'(STEP_CLKS - 1);
  end

  assign phase     = phase_q;
  assign phase_end = (cnt_q == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LIST;
      cnt_q   <= '0;
    end else if (restart) begin
      phase_q <= PH_LIST;
      cnt_q   <= '0;
    end else if (phase_end) begin
      cnt_q <= '0;
      case (phase_q)
        PH_LIST: phase_q <= PH_ZOOM;
        PH_ZOOM: phase_q <= PH_YPOS;
        PH_YPOS: phase_q <= PH_XPOS;
        PH_XPOS: phase_q <= PH_HOST;
        default: phase_q <= PH_LIST;
      endcase
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_PHASE_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q != $past(phase_q)) && !$past(restart)) |-> ($past(cnt_q) == $past(last_cnt))); // R2
endmodule

// File: rtl/sprite_attr_capture.sv
module sprite_attr_capture
  import sprfetch_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int NUM_W  = 9,
  parameter int SEQS   = 96,
  parameter int LIST_A = 'h600,
  parameter int LIST_B = 'h680
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_start,
  input  logic                       builder_bank,
  input  phase_e                     phase,
  input  logic                       phase_end,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic [ADDR_W-1:0]          list_addr,
  output logic [NUM_W-1:0]           cur_num,
  output logic                       spr_valid,
  output logic [$clog2(SEQS)-1:0]    spr_index,
  output logic [NUM_W-1:0]           spr_num,
  output logic [DATA_W-1:0]          spr_zoom,
  output logic [DATA_W-1:0]          spr_ypos,
  output logic [DATA_W-1:0]          spr_xpos
);
  localparam int IDX_W = $clog2(SEQS);

  logic              active_q;
  logic              bank_q;
  logic [IDX_W-1:0]  idx_q;
  logic [NUM_W-1:0]  num_q;
  logic [DATA_W-1:0] zoom_q, ypos_q, xpos_q;
  logic              take;

  assign take      = active_q && phase_end && !line_start;
  assign cur_num   = num_q;
  assign list_addr = (bank_q ? ADDR_W'(LIST_A) : ADDR_W'(LIST_B)) + ADDR_W'(idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      bank_q    <= 1'b0;
      idx_q     <= '0;
      num_q     <= '0;
      zoom_q    <= '0;
      ypos_q    <= '0;
      xpos_q    <= '0;
      spr_valid <= 1'b0;
      spr_index <= '0;
      spr_num   <= '0;
      spr_zoom  <= '0;
      spr_ypos  <= '0;
      spr_xpos  <= '0;
    end else begin
      spr_valid <= 1'b0;
      if (line_start) begin
        active_q <= 1'b1;
        bank_q   <= builder_bank;
        idx_q    <= '0;
      end else if (take) begin
        case (phase)
          PH_LIST: num_q  <= mem_rdata[NUM_W-1:0];
          PH_ZOOM: zoom_q <= mem_rdata;
          PH_YPOS: ypos_q <= mem_rdata;
          PH_XPOS: xpos_q <= mem_rdata;
          default: begin
            spr_valid <= 1'b1;
            spr_index <= idx_q;
            spr_num   <= num_q;
            spr_zoom  <= zoom_q;
            spr_ypos  <= ypos_q;
            spr_xpos  <= xpos_q;
            if (idx_q == IDX_W'(SEQS - 1)) begin
              active_q <= 1'b0;
              idx_q    <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (idx_q <= IDX_W'(SEQS - 1))); // R5
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(active_q) && !$past(line_start)) |-> !spr_valid); // R5
endmodule

// File: rtl/host_slot_port.sv
module host_slot_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_addr_we,
  input  logic              host_mod_we,
  input  logic              host_data_we,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              slot_enter,
  input  logic              slot_done,
  input  logic              slot_abort,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              slot_wr,
  output logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] host_rdata,
  output logic              wr_pending
);
  logic [ADDR_W-1:0] addr_q, mod_q;
  logic [DATA_W-1:0] wl_q, q_data;
  logic              pend_q, q_valid;
  logic              slot_wr_q;
  logic              wr_done;
  logic              pend_after;

  assign slot_wr    = slot_wr_q;
  assign host_addr  = addr_q;
  assign wr_data    = wl_q;
  assign wr_pending = pend_q;
  assign wr_done    = slot_done && slot_wr_q;

  always_comb begin
    pend_after = pend_q;
    if (wr_done && !q_valid) pend_after = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      mod_q      <= '0;
      wl_q       <= '0;
      q_data     <= '0;
      pend_q     <= 1'b0;
      q_valid    <= 1'b0;
      slot_wr_q  <= 1'b0;
      host_rdata <= '0;
    end else begin
      if (slot_abort)      slot_wr_q <= 1'b0;
      else if (slot_enter) slot_wr_q <= pend_q;
      else if (slot_done)  slot_wr_q <= 1'b0;

      if (slot_done && !slot_wr_q) host_rdata <= mem_rdata;

      if (host_addr_we)  addr_q <= host_wdata[ADDR_W-1:0];
      else if (wr_done)  addr_q <= addr_q + mod_q;

      if (host_mod_we) mod_q <= host_wdata[ADDR_W-1:0];

      pend_q <= pend_after;
      if (wr_done && q_valid) begin
        wl_q    <= q_data;
        q_valid <= 1'b0;
      end
      if (host_data_we) begin
        if (pend_after) begin
          q_data  <= host_wdata;
          q_valid <= 1'b1;
        end else begin
          wl_q   <= host_wdata;
          pend_q <= 1'b1;
        end
      end
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_done) && !$past(host_addr_we)) |-> (addr_q == ADDR_W'($past(addr_q) + $past(mod_q)))); // R7
  AST_QUEUE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> pend_q); // R8
  AST_WRITE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_data_we) |-> pend_q); // R7
endmodule

// File: rtl/sprite_fetch_seq.sv
module sprite_fetch_seq
  import sprfetch_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int NUM_W         = 9,
  parameter int SEQS_PER_LINE = 96,
  parameter int LIST_CLKS     = 4,
  parameter int STEP_CLKS     = 3,
  parameter int ZOOM_BASE     = 'h000,
  parameter int YPOS_BASE     = 'h200,
  parameter int XPOS_BASE     = 'h400,
  parameter int LIST_A        = 'h600,
  parameter int LIST_B        = 'h680
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             line_start,
  input  logic                             builder_bank,
  output logic [ADDR_W-1:0]                mem_addr,
  output logic                             mem_we,
  output logic [DATA_W-1:0]                mem_wdata,
  input  logic [DATA_W-1:0]                mem_rdata,
  input  logic                             host_addr_we,
  input  logic                             host_mod_we,
  input  logic                             host_data_we,
  input  logic [DATA_W-1:0]                host_wdata,
  output logic [DATA_W-1:0]                host_rdata,
  output logic                             host_wr_pending,
  output logic                             spr_valid,
  output logic [$clog2(SEQS_PER_LINE)-1:0] spr_index,
  output logic [NUM_W-1:0]                 spr_num,
  output logic [DATA_W-1:0]                spr_zoom,
  output logic [DATA_W-1:0]                spr_ypos,
  output logic [DATA_W-1:0]                spr_xpos
);
  phase_e            phase;
  logic              phase_end;
  logic [ADDR_W-1:0] list_addr, host_addr;
  logic [NUM_W-1:0]  cur_num;
  logic              slot_enter, slot_done, slot_wr;

  assign slot_enter = (phase == PH_XPOS) && phase_end && !line_start;
  assign slot_done  = (phase == PH_HOST) && phase_end && !line_start;

  seq_phase_timer #(.LIST_CLKS(LIST_CLKS), .STEP_CLKS(STEP_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(line_start),
    .phase(phase), .phase_end(phase_end)
  );

  sprite_attr_capture #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_W(NUM_W), .SEQS(SEQS_PER_LINE),
    .LIST_A(LIST_A), .LIST_B(LIST_B)
  ) u_capture (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .builder_bank(builder_bank),
    .phase(phase), .phase_end(phase_end), .mem_rdata(mem_rdata),
    .list_addr(list_addr), .cur_num(cur_num),
    .spr_valid(spr_valid), .spr_index(spr_index), .spr_num(spr_num),
    .spr_zoom(spr_zoom), .spr_ypos(spr_ypos), .spr_xpos(spr_xpos)
  );

  host_slot_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
    .clk(clk), .rst_n(rst_n),
    .host_addr_we(host_addr_we), .host_mod_we(host_mod_we),
    .host_data_we(host_data_we), .host_wdata(host_wdata),
    .slot_enter(slot_enter), .slot_done(slot_done), .slot_abort(line_start),
    .mem_rdata(mem_rdata),
    .slot_wr(slot_wr), .host_addr(host_addr), .wr_data(mem_wdata),
    .host_rdata(host_rdata), .wr_pending(host_wr_pending)
  );

  always_comb begin
    case (phase)
      PH_LIST: mem_addr = list_addr;
      PH_ZOOM: mem_addr = ADDR_W'(ZOOM_BASE) + ADDR_W'(cur_num);
      PH_YPOS: mem_addr = ADDR_W'(YPOS_BASE) + ADDR_W'(cur_num);
      PH_XPOS: mem_addr = ADDR_W'(XPOS_BASE) + ADDR_W'(cur_num);
      default: mem_addr = host_addr;
    endcase
  end

  assign mem_we = slot_wr && (phase == PH_HOST);

  AST_WE_IN_HOST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase == PH_HOST)); // R1
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    spr_valid |=> !spr_valid); // R3
  AST_VALID_AFTER_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    spr_valid |-> ($past(phase) == PH_HOST)); // R3
endmodule

// File: tb/sprite_fetch_seq_bench.sv
module sprite_fetch_seq_bench;
  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic        builder_bank = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, host_wdata, host_rdata;
  logic        mem_we, host_addr_we = 1'b0, host_mod_we = 1'b0, host_data_we = 1'b0;
  logic        host_wr_pending, spr_valid;
  logic [6:0]  spr_index;
  logic [8:0]  spr_num;
  logic [15:0] spr_zoom, spr_ypos, spr_xpos;

  logic [15:0] mem [0:2047];
  int tests = 0, fails = 0;
  int cyc = 0;
  int t0 = 0;
  int kexp = 0;
  int line_on = 0;
  int list_base = 0;

  always #(CYC/2) clk = ~clk;

  sprite_fetch_seq u_sprite_fetch_seq (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .builder_bank(builder_bank),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .host_addr_we(host_addr_we), .host_mod_we(host_mod_we), .host_data_we(host_data_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_wr_pending(host_wr_pending),
    .spr_valid(spr_valid), .spr_index(spr_index), .spr_num(spr_num),
    .spr_zoom(spr_zoom), .spr_ypos(spr_ypos), .spr_xpos(spr_xpos)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[10:0]];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int num_at(input int k);
    return int'(mem[list_base + k][8:0]);
  endfunction

  // monitor: samples a quarter period after each rising edge
  always @(posedge clk) begin
    #(CYC/4);
    if (line_on != 0) begin
      int rel;
      int n;
      rel = cyc - t0;
      if (rel >= 0 && rel < 16) begin
        int ea;
        n = num_at(0);
        if (rel < 4)       ea = list_base;
        else if (rel < 7)  ea = n;
        else if (rel < 10) ea = 'h200 + n;
        else if (rel < 13) ea = 'h400 + n;
        else               ea = -1;
        if (ea >= 0) chk(int'(mem_addr) == ea, (rel < 4) ? "R4 list address" : "R1/R2 phase address", int'(mem_addr), ea);
      end
    end
    if (spr_valid) begin
      if (line_on == 0) chk(1'b0, "R5 pulse outside line", int'(spr_index), -1);
      else begin
        int n;
        n = num_at(kexp);
        chk(cyc - t0 == 16 * (kexp + 1), "R3 pulse timing", cyc - t0, 16 * (kexp + 1));
        chk(int'(spr_index) == kexp, "R3 index", int'(spr_index), kexp);
        chk(int'(spr_num) == n, "R10 sprite number", int'(spr_num), n);
        chk(spr_zoom == mem[n] && spr_ypos == mem['h200 + n] && spr_xpos == mem['h400 + n],
            "R1 attribute words", int'(spr_xpos), int'(mem['h400 + n]));
        kexp++;
      end
    end
  end

  task automatic host_wr(input int kind, input logic [15:0] v);
    @(negedge clk);
    host_wdata = v;
    host_addr_we = (kind == 0);
    host_mod_we  = (kind == 1);
    host_data_we = (kind == 2);
    @(negedge clk);
    host_addr_we = 1'b0; host_mod_we = 1'b0; host_data_we = 1'b0;
  endtask

  task automatic run_line(input logic bank);
    @(negedge clk);
    builder_bank = bank;
    list_base = bank ? 'h600 : 'h680;
    kexp = 0;
    line_start = 1'b1;
    t0 = cyc + 1;
    line_on = 1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (1700) @(negedge clk);
    chk(kexp == 96, "R5 pulses per line", kexp, 96);
    line_on = 0;
  endtask

  initial begin
    #(CYC * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 2048; a++) mem[a] = 16'((a * 37 + 5) ^ (a >> 3));
    for (int i = 0; i < 96; i++) begin
      mem['h600 + i] = {7'h55, 9'((i * 5 + 1) % 512)};
      mem['h680 + i] = {7'h2A, 9'((i * 11 + 200) % 512)};
    end
    host_wdata = '0;
    repeat (5) @(negedge clk);
    chk(!spr_valid && !mem_we && !host_wr_pending && host_rdata == 16'h0, "R9 reset state",
        int'(host_rdata), 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk(!spr_valid, "R5 idle no pulse", int'(spr_valid), 0);

    run_line(1'b0);
    run_line(1'b1);

    // R6 background read
    host_wr(0, 16'h0720);
    repeat (40) @(negedge clk);
    chk(host_rdata == mem['h720], "R6 read latch", int'(host_rdata), int'(mem['h720]));

    // R7 single write with step 3
    host_wr(1, 16'd3);
    host_wr(0, 16'h0730);
    host_wr(2, 16'hBEEF);
    chk(host_wr_pending, "R7 pending after write", int'(host_wr_pending), 1);
    repeat (50) @(negedge clk);
    chk(mem['h730] == 16'hBEEF, "R7 written word", int'(mem['h730]), 'hBEEF);
    chk(!host_wr_pending, "R7 pending cleared", int'(host_wr_pending), 0);
    chk(host_rdata == mem['h733], "R7 address stepped", int'(host_rdata), int'(mem['h733]));

    // R8 back-to-back writes with step 2
    host_wr(1, 16'd2);
    host_wr(0, 16'h0740);
    @(negedge clk);
    host_wdata = 16'h1111; host_data_we = 1'b1;
    @(negedge clk);
    host_wdata = 16'h2222;
    @(negedge clk);
    host_data_we = 1'b0;
    repeat (80) @(negedge clk);
    chk(mem['h740] == 16'h1111, "R8 first write", int'(mem['h740]), 'h1111);
    chk(mem['h742] == 16'h2222, "R8 queued write", int'(mem['h742]), 'h2222);
    chk(host_rdata == mem['h744], "R8 final address", int'(host_rdata), int'(mem['h744]));
    chk(!host_wr_pending, "R8 queue drained", int'(host_wr_pending), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule